// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged L1 Read Cache

This block is the lookup side of a 4-way set-associative level-one data cache. It serves a 32-bit physical address space with 16 KB of storage: 128 sets, each holding 4 lines of 32 bytes. A load arrives as the untranslated low bits of its virtual address. With 4 KB pages those bits are the same in the virtual and the physical address, so the block reads the whole set (tags, valid bits and the addressed word of every way) in the same cycle it accepts the request. The address translator runs in parallel.

The translated physical page number arrives one or more cycles later on a separate input with a valid flag. It serves as the 20-bit tag and is compared against the four stored tags.

- **Hit:** the block returns the addressed 32-bit word.
- **Miss:** the block asks the next memory level for the full 32-byte line and waits for it. It installs the line in a victim way, then returns the word marked as a miss.

The block handles one request at a time. All data interfaces are valid/ready.

- **Request side:** a request is taken only when `req_valid` and `req_ready` are both high on a clock edge.
- **Line fetch:** `fill_req_valid` and `fill_req_addr` hold until `fill_req_ready` accepts them.
- **Returned line:** it is taken on `fill_rsp_valid` while `fill_rsp_ready` is high.
- **Response:** it holds unchanged while `rsp_ready` is low.

Top module: `vipt_l1_lookup`

## Requirements
- R1: Reset clears every line's valid bit and every per-set replacement pointer (to way 0). After reset `req_ready` is 1 and `rsp_valid`, `fill_req_valid` and `fill_rsp_ready` are 0, so the first access to any address misses.
- R2: A request is accepted only when the block is idle. `req_ready` stays 0 from the accepting edge until the edge that completes the response handshake.
- R3: Hit or miss is not decided before the page number is valid. While the block waits for `ppn_valid`, `rsp_valid` and `fill_req_valid` stay 0, and `ppn` is ignored.
- R4: The set is chosen only by virtual bits 11:5 (`req_vaddr_word[9:3]`), and the word by bits 4:2 (`req_vaddr_word[2:0]`). If a valid way's tag equals `ppn` on the edge where `ppn_valid` is 1, `rsp_valid` rises in the next cycle with `rsp_hit`=1 and `rsp_data` set to that word of the line.
- R5: On a miss, `fill_req_valid` rises in the cycle after the `ppn_valid` edge, with `fill_req_addr` = {ppn, set index, 5'b0}. Both hold until `fill_req_ready` is 1 at an edge.
- R6: After the fetch is accepted, `fill_rsp_ready` is 1 until `fill_rsp_valid` is seen. In the returned line, word w occupies bits 32w+31:32w. In the next cycle `rsp_valid` is 1 with `rsp_hit`=0 and `rsp_data` holding the requested word of that line.
- R7: A refilled line is stored with its page number as tag, so a later access with the same set, page number and any word offset hits.
- R8: The victim way is chosen as follows:
  - If the set has an invalid way, the lowest-numbered invalid way is filled.
  - Otherwise the set's round-robin pointer picks the way, and the pointer then advances by one, wrapping from 3 to 0.
  - The pointer does not move when an invalid way is filled.
- R9: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid`, `rsp_data` and `rsp_hit` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Load request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_vaddr_word | input | 10 | Virtual address bits 11:2 (set index and word) |
| ppn_valid | input | 1 | Translated page number is valid |
| ppn | input | 20 | Translated physical page number |
| rsp_valid | output | 1 | Load response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | 32 | Returned word |
| rsp_hit | output | 1 | 1 when the word came from a resident line |
| fill_req_valid | output | 1 | Line fetch request to next level |
| fill_req_ready | input | 1 | Next level accepts the fetch |
| fill_req_addr | output | 32 | Line-aligned physical address of the fetch |
| fill_rsp_valid | input | 1 | Fetched line present |
| fill_rsp_ready | output | 1 | Block is waiting for the fetched line |
| fill_rsp_data | input | 256 | Fetched line, word w at bits 32w+31:32w |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, 4 KB pages, 32-byte lines, 4 ways, 32-bit words, and therefore 128 sets. Random traffic is confined to four sets, including sets 0 and 127, and to six page numbers. Each set therefore sees more distinct tags than it has ways, so the invalid-way preference, round-robin eviction after a set fills and re-hits after refill all come within reach in a few hundred accesses. Translation delays, fetch stalls and response stalls vary from zero to several cycles, so the wait, hold and back-pressure rules are exercised at their edges.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_XLATE,
    ST_FREQ,
    ST_FWAIT,
    ST_RESP
  } lookup_st_e;
endpackage

// File: rtl/vipt_tag_store.sv
module vipt_tag_store #(
  parameter int SETS  = 128,
  parameter int WAYS  = 4,
  parameter int TAG_W = 20,
  parameter int IDX_W = 7,
  parameter int WAY_W = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [IDX_W-1:0]            rd_idx_i,
  output logic [WAYS-1:0][TAG_W-1:0]  rd_tags_o,
  output logic [WAYS-1:0]             rd_valid_o,
  output logic [WAY_W-1:0]            rd_rr_o,
  input  logic                        wr_en_i,
  input  logic [IDX_W-1:0]            wr_idx_i,
  input  logic [WAY_W-1:0]            wr_way_i,
  input  logic [TAG_W-1:0]            wr_tag_i,
  input  logic                        rr_adv_i
);
  logic [TAG_W-1:0] tag_mem [SETS][WAYS];
  logic [WAYS-1:0]  valid_q [SETS];
  logic [WAY_W-1:0] rr_q    [SETS];

  for (genvar w = 0; w < WAYS; w++) begin : g_rd
    assign rd_tags_o[w] = tag_mem[rd_idx_i][w];
  end
  assign rd_valid_o = valid_q[rd_idx_i];
  assign rd_rr_o    = rr_q[rd_idx_i];

  always_ff @(posedge clk) begin
    if (wr_en_i) tag_mem[wr_idx_i][wr_way_i] <= wr_tag_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        rr_q[s]    <= '0;
      end
    end else if (wr_en_i) begin
      valid_q[wr_idx_i][wr_way_i] <= 1'b1;
      if (rr_adv_i) begin
        rr_q[wr_idx_i] <= (wr_way_i == WAY_W'(WAYS - 1)) ? '0 : wr_way_i + 1'b1;
      end
    end
  end
endmodule

// File: rtl/vipt_data_store.sv
module vipt_data_store #(
  parameter int SETS   = 128,
  parameter int WAYS   = 4,
  parameter int LINE_W = 256,
  parameter int WORD_W = 32,
  parameter int IDX_W  = 7,
  parameter int WSEL_W = 3,
  parameter int WAY_W  = 2
) (
  input  logic                         clk,
  input  logic [IDX_W-1:0]             rd_idx_i,
  input  logic [WSEL_W-1:0]            rd_wsel_i,
  output logic [WAYS-1:0][WORD_W-1:0]  rd_words_o,
  input  logic                         wr_en_i,
  input  logic [IDX_W-1:0]             wr_idx_i,
  input  logic [WAY_W-1:0]             wr_way_i,
  input  logic [LINE_W-1:0]            wr_line_i
);
  logic [LINE_W-1:0] line_mem [SETS][WAYS];

  for (genvar w = 0; w < WAYS; w++) begin : g_rd
    assign rd_words_o[w] = line_mem[rd_idx_i][w][int'(rd_wsel_i)*WORD_W +: WORD_W];
  end

  always_ff @(posedge clk) begin
    if (wr_en_i) line_mem[wr_idx_i][wr_way_i] <= wr_line_i;
  end
endmodule

// File: rtl/vipt_victim_pick.sv
module vipt_victim_pick #(
  parameter int WAYS  = 4,
  parameter int WAY_W = 2
) (
  input  logic [WAYS-1:0]  valid_i,
  input  logic [WAY_W-1:0] rr_i,
  output logic [WAY_W-1:0] way_o,
  output logic             from_rr_o
);
  always_comb begin
    way_o     = rr_i;
    from_rr_o = 1'b1;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (!valid_i[i]) begin
        way_o     = WAY_W'(i);
        from_rr_o = 1'b0;
      end
    end
  end
endmodule

// File: rtl/vipt_l1_lookup.sv
module vipt_l1_lookup
  import vipt_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PAGE_W     = 12,
  parameter int LINE_BYTES = 32,
  parameter int WAYS       = 4,
  parameter int WORD_W     = 32,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int BYTE_W    = $clog2(WORD_W / 8),
  localparam int IDX_W     = PAGE_W - OFF_W,
  localparam int TAG_W     = ADDR_W - PAGE_W,
  localparam int VA_W      = PAGE_W - BYTE_W,
  localparam int LINE_W    = LINE_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr_word,
  input  logic              ppn_valid,
  input  logic [TAG_W-1:0]  ppn,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [WORD_W-1:0] rsp_data,
  output logic              rsp_hit,
  output logic              fill_req_valid,
  input  logic              fill_req_ready,
  output logic [ADDR_W-1:0] fill_req_addr,
  input  logic              fill_rsp_valid,
  output logic              fill_rsp_ready,
  input  logic [LINE_W-1:0] fill_rsp_data
);
  localparam int SETS   = 1 << IDX_W;
  localparam int WORDS  = LINE_W / WORD_W;
  localparam int WSEL_W = $clog2(WORDS);
  localparam int WAY_W  = $clog2(WAYS);

  lookup_st_e st_q;

  // set snapshot taken when the request is accepted
  logic [IDX_W-1:0]            idx_q;
  logic [WSEL_W-1:0]           wsel_q;
  logic [WAYS-1:0][TAG_W-1:0]  tags_q;
  logic [WAYS-1:0]             vld_q;
  logic [WAYS-1:0][WORD_W-1:0] words_q;
  logic [WAY_W-1:0]            rr_q;
  logic [TAG_W-1:0]            ppn_q;
  logic [WORD_W-1:0]           rsp_data_q;
  logic                        rsp_hit_q;

  logic [IDX_W-1:0]            req_idx;
  logic [WSEL_W-1:0]           req_wsel;
  logic [WAYS-1:0][TAG_W-1:0]  rd_tags;
  logic [WAYS-1:0]             rd_valid;
  logic [WAY_W-1:0]            rd_rr;
  logic [WAYS-1:0][WORD_W-1:0] rd_words;
  logic [WAYS-1:0]             hit_vec;
  logic [WORD_W-1:0]           hit_word;
  logic [WAY_W-1:0]            victim;
  logic                        victim_rr;
  logic                        fill_we;
  logic                        accept;

  assign req_idx  = req_vaddr_word[VA_W-1 -: IDX_W];
  assign req_wsel = req_vaddr_word[WSEL_W-1:0];

  assign req_ready      = (st_q == ST_IDLE);
  assign accept         = req_valid && req_ready;
  assign fill_req_valid = (st_q == ST_FREQ);
  assign fill_rsp_ready = (st_q == ST_FWAIT);
  assign rsp_valid      = (st_q == ST_RESP);
  assign rsp_data       = rsp_data_q;
  assign rsp_hit        = rsp_hit_q;
  assign fill_req_addr  = {ppn_q, idx_q, {OFF_W{1'b0}}};
  assign fill_we        = fill_rsp_valid && fill_rsp_ready;

  vipt_tag_store #(
    .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .IDX_W(IDX_W), .WAY_W(WAY_W)
  ) u_tags (
    .clk(clk), .rst_n(rst_n),
    .rd_idx_i(req_idx), .rd_tags_o(rd_tags), .rd_valid_o(rd_valid), .rd_rr_o(rd_rr),
    .wr_en_i(fill_we), .wr_idx_i(idx_q), .wr_way_i(victim), .wr_tag_i(ppn_q),
    .rr_adv_i(victim_rr)
  );

  vipt_data_store #(
    .SETS(SETS), .WAYS(WAYS), .LINE_W(LINE_W), .WORD_W(WORD_W),
    .IDX_W(IDX_W), .WSEL_W(WSEL_W), .WAY_W(WAY_W)
  ) u_data (
    .clk(clk),
    .rd_idx_i(req_idx), .rd_wsel_i(req_wsel), .rd_words_o(rd_words),
    .wr_en_i(fill_we), .wr_idx_i(idx_q), .wr_way_i(victim), .wr_line_i(fill_rsp_data)
  );

  vipt_victim_pick #(.WAYS(WAYS), .WAY_W(WAY_W)) u_victim (
    .valid_i(vld_q), .rr_i(rr_q), .way_o(victim), .from_rr_o(victim_rr)
  );

  // tag compare against the translated page number
  always_comb begin
    hit_word = '0;
    for (int w = 0; w < WAYS; w++) begin
      hit_vec[w] = vld_q[w] && (tags_q[w] == ppn);
      if (hit_vec[w]) hit_word = hit_word | words_q[w];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else begin
      case (st_q)
        ST_IDLE:  if (accept) st_q <= ST_XLATE;
        ST_XLATE: if (ppn_valid) st_q <= (|hit_vec) ? ST_RESP : ST_FREQ;
        ST_FREQ:  if (fill_req_ready) st_q <= ST_FWAIT;
        ST_FWAIT: if (fill_rsp_valid) st_q <= ST_RESP;
        ST_RESP:  if (rsp_ready) st_q <= ST_IDLE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q      <= '0;
      wsel_q     <= '0;
      tags_q     <= '0;
      vld_q      <= '0;
      words_q    <= '0;
      rr_q       <= '0;
      ppn_q      <= '0;
      rsp_data_q <= '0;
      rsp_hit_q  <= 1'b0;
    end else begin
      if (accept) begin
        idx_q   <= req_idx;
        wsel_q  <= req_wsel;
        tags_q  <= rd_tags;
        vld_q   <= rd_valid;
        words_q <= rd_words;
        rr_q    <= rd_rr;
      end
      if (st_q == ST_XLATE && ppn_valid) begin
        ppn_q <= ppn;
        if (|hit_vec) begin
          rsp_data_q <= hit_word;
          rsp_hit_q  <= 1'b1;
        end
      end
      if (fill_we) begin
        rsp_data_q <= fill_rsp_data[int'(wsel_q)*WORD_W +: WORD_W];
        rsp_hit_q  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/vipt_l1_checker.sv
module vipt_l1_checker #(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              ppn_valid,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [WORD_W-1:0] rsp_data,
  input logic              rsp_hit,
  input logic              fill_req_valid,
  input logic              fill_req_ready,
  input logic [ADDR_W-1:0] fill_req_addr,
  input logic              fill_rsp_ready
);
  a_r2_busy_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);
  a_r2_busy_fill: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req_valid |-> !req_ready);
  a_r3_wait_xlate: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!rsp_valid && !fill_req_valid));
  a_r4_hit_after_ppn: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rsp_valid) && rsp_hit) |-> $past(ppn_valid));
  a_r5_fill_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req_valid && !fill_req_ready) |=> (fill_req_valid && $stable(fill_req_addr)));
  a_r6_fill_wait_alone: assert property (@(posedge clk) disable iff (!rst_n)
    fill_rsp_ready |-> (!fill_req_valid && !rsp_valid && !req_ready));
  a_r9_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_hit)));
endmodule

bind vipt_l1_lookup vipt_l1_checker #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (.*);

// File: tb/tb_vipt_l1_lookup.sv
module tb_vipt_l1_lookup;
  localparam int WAYS = 4;
  localparam int SETS = 128;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [9:0]   req_vaddr_word = '0;
  logic         ppn_valid = 1'b0;
  logic [19:0]  ppn = '0;
  logic         rsp_valid;
  logic         rsp_ready = 1'b0;
  logic [31:0]  rsp_data;
  logic         rsp_hit;
  logic         fill_req_valid;
  logic         fill_req_ready = 1'b0;
  logic [31:0]  fill_req_addr;
  logic         fill_rsp_valid = 1'b0;
  logic         fill_rsp_ready;
  logic [255:0] fill_rsp_data = '0;

  int total = 0;
  int bad = 0;

  bit          m_valid [SETS][WAYS];
  logic [19:0] m_tag   [SETS][WAYS];
  int          m_rr    [SETS];

  always #2 clk = ~clk;

  vipt_l1_lookup dut (.*);

  function automatic logic [31:0] mem_word(logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h5A5A0F0F ^ (a >> 7);
  endfunction

  function automatic logic [255:0] mem_line(logic [31:0] base);
    logic [255:0] l;
    for (int w = 0; w < 8; w++) l[w*32 +: 32] = mem_word(base + 32'(w * 4));
    return l;
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic do_access(input int idx, input int wsel, input logic [19:0] pn,
                           input int xl_dly, input int fill_dly, input int rsp_dly,
                           input string tag);
    logic [31:0] pa, line_a, exp_w;
    int hw, vict;
    bit exp_hit;
    pa     = {pn, 7'(idx), 3'(wsel), 2'b00};
    line_a = {pn, 7'(idx), 5'b0};
    exp_w  = mem_word(pa);
    exp_hit = 1'b0;
    hw = -1;
    for (int w = 0; w < WAYS; w++)
      if (m_valid[idx][w] && m_tag[idx][w] == pn) begin exp_hit = 1'b1; hw = w; end

    chk(req_ready == 1'b1, "R2", 64'(req_ready), 64'd1);
    req_valid = 1'b1;
    req_vaddr_word = {7'(idx), 3'(wsel)};
    @(negedge clk);
    req_valid = 1'b0;
    req_vaddr_word = 10'($urandom);
    for (int d = 0; d <= xl_dly; d++) begin
      // R3: no decision while translation is pending, ppn ignored
      ppn = 20'($urandom);
      chk(!rsp_valid && !fill_req_valid && !req_ready, "R3",
          {61'd0, rsp_valid, fill_req_valid, req_ready}, 64'd0);
      if (d < xl_dly) @(negedge clk);
    end
    ppn_valid = 1'b1;
    ppn = pn;
    @(negedge clk);
    ppn_valid = 1'b0;
    ppn = 20'($urandom);

    chk(rsp_valid == exp_hit, tag, 64'(rsp_valid), 64'(exp_hit));
    if (exp_hit) begin
      chk(rsp_hit == 1'b1 && rsp_data == exp_w, "R4", {31'd0, rsp_hit, rsp_data}, {32'd1, exp_w});
    end else begin
      chk(fill_req_valid && fill_req_addr == line_a, "R5",
          {31'd0, fill_req_valid, fill_req_addr}, {32'd1, line_a});
      for (int d = 0; d < fill_dly; d++) begin
        @(negedge clk);
        chk(fill_req_valid && fill_req_addr == line_a, "R5",
            {31'd0, fill_req_valid, fill_req_addr}, {32'd1, line_a});
      end
      fill_req_ready = 1'b1;
      @(negedge clk);
      fill_req_ready = 1'b0;
      for (int d = 0; d <= fill_dly; d++) begin
        chk(fill_rsp_ready && !rsp_valid, "R6", {62'd0, fill_rsp_ready, rsp_valid}, 64'd2);
        if (d < fill_dly) @(negedge clk);
      end
      fill_rsp_valid = 1'b1;
      fill_rsp_data = mem_line(line_a);
      @(negedge clk);
      fill_rsp_valid = 1'b0;
      fill_rsp_data = {8{$urandom}};
      chk(rsp_valid && !rsp_hit && rsp_data == exp_w, "R6",
          {30'd0, rsp_valid, rsp_hit, rsp_data}, {32'd2, exp_w});
      vict = -1;
      for (int w = WAYS - 1; w >= 0; w--) if (!m_valid[idx][w]) vict = w;
      if (vict < 0) begin
        vict = m_rr[idx];
        m_rr[idx] = (m_rr[idx] + 1) % WAYS;
      end
      m_valid[idx][vict] = 1'b1;
      m_tag[idx][vict] = pn;
    end
    for (int d = 0; d < rsp_dly; d++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_data == exp_w && rsp_hit == exp_hit, "R9",
          {31'd0, rsp_valid, rsp_data}, {32'd1, exp_w});
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(req_ready && !rsp_valid, "R2", {62'd0, req_ready, rsp_valid}, 64'd2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int sets_pool[4];
    logic [19:0] pn_pool[6];
    void'($urandom(32'd1234));
    sets_pool = '{3, 5, 127, 0};
    pn_pool = '{20'h00001, 20'h0ABCD, 20'hFFFFF, 20'h12345, 20'h00000, 20'h7F00F};
    for (int s = 0; s < SETS; s++) begin
      m_rr[s] = 0;
      for (int w = 0; w < WAYS; w++) begin m_valid[s][w] = 1'b0; m_tag[s][w] = '0; end
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle outputs after reset
    chk(req_ready && !rsp_valid && !fill_req_valid && !fill_rsp_ready, "R1",
        {60'd0, req_ready, rsp_valid, fill_req_valid, fill_rsp_ready}, 64'h8);
    // R1: first access misses; R7: same line then hits at another word
    do_access(9, 2, 20'h00D00, 0, 0, 0, "R1");
    do_access(9, 7, 20'h00D00, 2, 0, 1, "R7");
    // R8: fill four ways, then round-robin eviction from way 0
    do_access(5, 0, 20'h0000A, 0, 1, 0, "R8");
    do_access(5, 1, 20'h0000B, 1, 0, 0, "R8");
    do_access(5, 2, 20'h0000C, 0, 2, 0, "R8");
    do_access(5, 3, 20'h0000D, 0, 0, 2, "R8");
    do_access(5, 4, 20'h0000E, 0, 0, 0, "R8");
    do_access(5, 5, 20'h0000A, 0, 0, 0, "R8");
    do_access(5, 6, 20'h0000C, 0, 0, 0, "R8");
    do_access(5, 7, 20'h0000E, 3, 0, 0, "R8");
    do_access(5, 0, 20'h0000B, 0, 0, 0, "R8");
    // R4: same page number in another set stays separate
    do_access(6, 0, 20'h0000A, 0, 0, 0, "R4");
    do_access(9, 0, 20'h00D00, 0, 0, 3, "R7");
    for (int n = 0; n < 400; n++) begin
      do_access(sets_pool[$urandom_range(0, 3)], int'($urandom_range(0, 7)),
                pn_pool[$urandom_range(0, 5)], int'($urandom_range(0, 2)),
                int'($urandom_range(0, 2)), int'($urandom_range(0, 2)), "R8");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule